// File: doc/BRIEF.md
# Offload Dependency Scoreboard

This block is the issue-control stage of a single-issue, in-order 32-bit integer core that hands some instructions to external accelerators, such as a shared multiply/divide unit or a private floating-point unit. It tracks which architectural registers still wait for an accelerator result. Independent later instructions keep issuing while those results are outstanding. An instruction stalls only when it reads (RAW) or overwrites (WAW) a register that is still pending.

Each cycle the decoder presents one instruction: two source indices with use flags, a destination index with a write flag, and an offload flag. The block answers with issue or stall. For an offloaded instruction it also raises a request toward the accelerator, and the instruction issues only when the accelerator accepts that request. Accelerator writebacks land in a register file held inside the block and clear the pending mark. The two source operands are read from that register file. The block also keeps the program counter of the next instruction to issue.

Top module: `offload_scoreboard`

## Requirements
- R1: After reset the program counter equals BOOT_ADDR and no register is pending, so any instruction without an offload issues at once.
- R2: At most one instruction issues per cycle. `pc_o` advances by 4 in the cycle after an issue and holds in the cycle after a stall.
- R3: A valid instruction that uses source rs1 or rs2 while that register is pending raises `stall_o`, with `issue_o` and `acc_req_valid_o` low.
- R4: A valid instruction with its write flag set whose destination is pending stalls, whether or not it is an offload.
- R5: With no RAW or WAW hazard, a non-offload instruction issues in the same cycle, even while other registers are pending.
- R6: A hazard-free offload raises `acc_req_valid_o`. It issues only when `acc_req_ready_i` is 1. Otherwise it stalls and marks nothing pending.
- R7: A writeback in cycle N writes `wb_data_i` to register `wb_rd_i` and clears its pending mark. An instruction in cycle N+1 that reads that register issues and sees the value on `rs1_data_o`/`rs2_data_o`.
- R8: When a writeback to register r and an issuing offload with destination r fall in the same cycle, r is pending afterwards.
- R9: Register 0 is never marked pending and always reads as 0.
- R10: A writeback is accepted in a cycle where the instruction stalls, and the stalled instruction issues in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dec_valid_i | input | 1 | A decoded instruction is presented |
| dec_rs1_i | input | 5 | First source register index |
| dec_rs1_use_i | input | 1 | First source is read |
| dec_rs2_i | input | 5 | Second source register index |
| dec_rs2_use_i | input | 1 | Second source is read |
| dec_rd_i | input | 5 | Destination register index |
| dec_rd_we_i | input | 1 | Destination is written |
| dec_offload_i | input | 1 | Instruction is executed by an accelerator |
| acc_req_valid_o | output | 1 | Offload request to the accelerator |
| acc_req_ready_i | input | 1 | Accelerator accepts the request |
| wb_valid_i | input | 1 | Accelerator writeback valid |
| wb_rd_i | input | 5 | Writeback register index |
| wb_data_i | input | 32 | Writeback value |
| issue_o | output | 1 | Instruction issues this cycle |
| stall_o | output | 1 | Valid instruction held this cycle |
| pc_o | output | 32 | Address of the next instruction to issue |
| rs1_data_o | output | 32 | Value of the first source register |
| rs2_data_o | output | 32 | Value of the second source register |

## Verification
The assertions assume that the decoder holds an instruction while it is stalled. They also assume that the accelerator returns at most one result per cycle. Neither the writeback-clear check nor the set-priority check requires the written-back register to be pending. The random stimulus takes writeback indices only from registers the bench model marks pending. It confines register indices to a small range so that RAW and WAW collisions occur often. The one stray writeback, to a register that is not pending, is a single directed case that exercises the set-over-clear priority.

// File: rtl/scb_pkg.sv
package scb_pkg;
    localparam int unsigned SCB_XLEN  = 32;
    localparam int unsigned SCB_NREGS = 32;
    localparam int unsigned SCB_ILEN_BYTES = 4;
endpackage

// File: rtl/scb_pending.sv
module scb_pending #(
    parameter int unsigned NUM_REGS = scb_pkg::SCB_NREGS,
    localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                set_en_i,
    input  logic [IDX_W-1:0]    set_idx_i,
    input  logic                clr_en_i,
    input  logic [IDX_W-1:0]    clr_idx_i,
    output logic [NUM_REGS-1:0] busy_o
);
    typedef struct packed {
        logic [NUM_REGS-1:0] busy;
    } pend_state_t;

    pend_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.busy[0] = 1'b0;
        for (int r = 1; r < NUM_REGS; r++) begin
            if (clr_en_i && clr_idx_i == IDX_W'(r)) st_d.busy[r] = 1'b0;
            if (set_en_i && set_idx_i == IDX_W'(r)) st_d.busy[r] = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign busy_o = st_q.busy;

    AST_ZERO_NEVER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o[0]); // R9
endmodule

// File: rtl/scb_regfile.sv
module scb_regfile #(
    parameter int unsigned XLEN     = scb_pkg::SCB_XLEN,
    parameter int unsigned NUM_REGS = scb_pkg::SCB_NREGS,
    localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             we_i,
    input  logic [IDX_W-1:0] waddr_i,
    input  logic [XLEN-1:0]  wdata_i,
    input  logic [IDX_W-1:0] raddr_a_i,
    input  logic [IDX_W-1:0] raddr_b_i,
    output logic [XLEN-1:0]  rdata_a_o,
    output logic [XLEN-1:0]  rdata_b_o
);
    logic [XLEN-1:0] regs_d [NUM_REGS];
    logic [XLEN-1:0] regs_q [NUM_REGS];

    always_comb begin
        regs_d = regs_q;
        if (we_i && waddr_i != '0) regs_d[waddr_i] = wdata_i;
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) regs_q[g] <= '0;
            else         regs_q[g] <= regs_d[g];
        end
    end

    assign rdata_a_o = (raddr_a_i == '0) ? '0 : regs_q[raddr_a_i];
    assign rdata_b_o = (raddr_b_i == '0) ? '0 : regs_q[raddr_b_i];

    AST_WB_VISIBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && waddr_i != '0) |=> regs_q[$past(waddr_i)] == $past(wdata_i)); // R7
endmodule

// File: rtl/scb_hazard.sv
module scb_hazard #(
    parameter int unsigned NUM_REGS = scb_pkg::SCB_NREGS,
    localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
    input  logic [NUM_REGS-1:0] busy_i,
    input  logic                valid_i,
    input  logic [IDX_W-1:0]    rs1_i,
    input  logic                rs1_use_i,
    input  logic [IDX_W-1:0]    rs2_i,
    input  logic                rs2_use_i,
    input  logic [IDX_W-1:0]    rd_i,
    input  logic                rd_we_i,
    output logic                raw_o,
    output logic                waw_o,
    output logic                hazard_o
);
    always_comb begin
        raw_o    = valid_i && ((rs1_use_i && busy_i[rs1_i]) || (rs2_use_i && busy_i[rs2_i]));
        waw_o    = valid_i && rd_we_i && busy_i[rd_i];
        hazard_o = raw_o || waw_o;
    end
endmodule

// File: rtl/offload_scoreboard.sv
module offload_scoreboard #(
    parameter int unsigned XLEN      = scb_pkg::SCB_XLEN,
    parameter int unsigned NUM_REGS  = scb_pkg::SCB_NREGS,
    parameter logic [31:0] BOOT_ADDR = 32'h8000_0000,
    localparam int unsigned IDX_W    = $clog2(NUM_REGS)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             dec_valid_i,
    input  logic [IDX_W-1:0] dec_rs1_i,
    input  logic             dec_rs1_use_i,
    input  logic [IDX_W-1:0] dec_rs2_i,
    input  logic             dec_rs2_use_i,
    input  logic [IDX_W-1:0] dec_rd_i,
    input  logic             dec_rd_we_i,
    input  logic             dec_offload_i,
    output logic             acc_req_valid_o,
    input  logic             acc_req_ready_i,
    input  logic             wb_valid_i,
    input  logic [IDX_W-1:0] wb_rd_i,
    input  logic [XLEN-1:0]  wb_data_i,
    output logic             issue_o,
    output logic             stall_o,
    output logic [31:0]      pc_o,
    output logic [XLEN-1:0]  rs1_data_o,
    output logic [XLEN-1:0]  rs2_data_o
);
    typedef struct packed {
        logic [31:0] pc;
    } core_state_t;

    core_state_t st_d, st_q;

    logic [NUM_REGS-1:0] busy;
    logic raw, waw, hazard;
    logic set_en;

    scb_hazard #(.NUM_REGS(NUM_REGS)) i_hazard (
        .busy_i   (busy),
        .valid_i  (dec_valid_i),
        .rs1_i    (dec_rs1_i),
        .rs1_use_i(dec_rs1_use_i),
        .rs2_i    (dec_rs2_i),
        .rs2_use_i(dec_rs2_use_i),
        .rd_i     (dec_rd_i),
        .rd_we_i  (dec_rd_we_i),
        .raw_o    (raw),
        .waw_o    (waw),
        .hazard_o (hazard)
    );

    always_comb begin
        acc_req_valid_o = dec_valid_i && dec_offload_i && !hazard;
        issue_o         = dec_valid_i && !hazard && (!dec_offload_i || acc_req_ready_i);
        stall_o         = dec_valid_i && !issue_o;
        set_en          = issue_o && dec_offload_i && dec_rd_we_i;
        st_d            = st_q;
        if (issue_o) st_d.pc = st_q.pc + 32'(scb_pkg::SCB_ILEN_BYTES);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{pc: BOOT_ADDR};
        else         st_q <= st_d;
    end

    assign pc_o = st_q.pc;

    scb_pending #(.NUM_REGS(NUM_REGS)) i_pending (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .set_en_i (set_en),
        .set_idx_i(dec_rd_i),
        .clr_en_i (wb_valid_i),
        .clr_idx_i(wb_rd_i),
        .busy_o   (busy)
    );

    scb_regfile #(.XLEN(XLEN), .NUM_REGS(NUM_REGS)) i_regfile (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .we_i     (wb_valid_i),
        .waddr_i  (wb_rd_i),
        .wdata_i  (wb_data_i),
        .raddr_a_i(dec_rs1_i),
        .raddr_b_i(dec_rs2_i),
        .rdata_a_o(rs1_data_o),
        .rdata_b_o(rs2_data_o)
    );

    AST_RS1_BUSY_STALLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dec_valid_i && dec_rs1_use_i && busy[dec_rs1_i]) |-> (stall_o && !issue_o && !acc_req_valid_o)); // R3
    AST_RD_BUSY_STALLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dec_valid_i && dec_rd_we_i && busy[dec_rd_i]) |-> (stall_o && !issue_o)); // R4
    AST_NOT_READY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc_req_valid_o && !acc_req_ready_i) |-> !issue_o); // R6
    AST_PC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        issue_o |=> pc_o == $past(pc_o) + 32'd4); // R2
    AST_PC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !issue_o |=> $stable(pc_o)); // R2
    AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (set_en && dec_rd_i != '0) |=> busy[$past(dec_rd_i)]); // R8
    AST_WB_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wb_valid_i && !(set_en && dec_rd_i == wb_rd_i)) |=> !busy[$past(wb_rd_i)]); // R7
endmodule

// File: tb/test_offload_scoreboard.sv
module test_offload_scoreboard;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] BOOT = 32'h8000_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic v, u1, u2, we, off, rdy, wbv;
    logic [4:0] r1, r2, rd, wbr;
    logic [31:0] wbd;
    logic acc_req, issue, stall;
    logic [31:0] pc, d1, d2;

    offload_scoreboard #(.BOOT_ADDR(BOOT)) i_offload_scoreboard (
        .clk_i(clk), .rst_ni(rst_n),
        .dec_valid_i(v), .dec_rs1_i(r1), .dec_rs1_use_i(u1),
        .dec_rs2_i(r2), .dec_rs2_use_i(u2), .dec_rd_i(rd), .dec_rd_we_i(we),
        .dec_offload_i(off), .acc_req_valid_o(acc_req), .acc_req_ready_i(rdy),
        .wb_valid_i(wbv), .wb_rd_i(wbr), .wb_data_i(wbd),
        .issue_o(issue), .stall_o(stall), .pc_o(pc),
        .rs1_data_o(d1), .rs2_data_o(d2)
    );

    int n_vec = 0;
    int n_bad = 0;
    logic m_pend [32];
    logic [31:0] m_rf [32];
    logic [31:0] m_pc;

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic drv(input logic iv, input logic [4:0] ir1, input logic iu1, input logic [4:0] ir2,
                       input logic iu2, input logic [4:0] ird, input logic iwe, input logic ioff,
                       input logic irdy, input logic iwbv, input logic [4:0] iwbr, input logic [31:0] iwbd);
        v = iv; r1 = ir1; u1 = iu1; r2 = ir2; u2 = iu2; rd = ird; we = iwe; off = ioff;
        rdy = irdy; wbv = iwbv; wbr = iwbr; wbd = iwbd;
    endtask

    function automatic logic f_raw();
        return v && ((u1 && m_pend[r1]) || (u2 && m_pend[r2]));
    endfunction
    function automatic logic f_waw();
        return v && we && m_pend[rd];
    endfunction

    // One cycle: check outputs against the model, then advance the model at the edge.
    task automatic cycle(input string force_tag);
        logic hz, e_iss, e_req;
        string tag;
        #1;
        hz    = f_raw() || f_waw();
        e_req = v && off && !hz;
        e_iss = v && !hz && (!off || rdy);
        tag   = f_raw() ? "R3" : f_waw() ? "R4" : (v && off && !rdy) ? "R6" : "R5";
        if (force_tag != "") tag = force_tag;
        chk(tag, "issue", 32'(issue), 32'(e_iss));
        chk(tag, "stall", 32'(stall), 32'(v && !e_iss));
        chk(tag, "acc_req", 32'(acc_req), 32'(e_req));
        chk("R2", "pc", pc, m_pc);
        if (v && u1) chk("R7", "rs1_data", d1, m_rf[r1]);
        if (v && u2) chk("R7", "rs2_data", d2, m_rf[r2]);
        @(posedge clk);
        if (wbv && wbr != 0) begin m_rf[wbr] = wbd; m_pend[wbr] = 1'b0; end
        if (e_iss && off && we && rd != 0) m_pend[rd] = 1'b1;
        if (e_iss) m_pc = m_pc + 32'd4;
        @(negedge clk);
    endtask

    task automatic idle();
        drv(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL R2 watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        for (int i = 0; i < 32; i++) begin m_pend[i] = 1'b0; m_rf[i] = '0; end
        m_pc = BOOT;
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state; a plain instruction issues at once
        chk("R1", "pc after reset", pc, BOOT);
        drv(1, 5, 1, 9, 1, 3, 1, 0, 0, 0, 0, 0);
        cycle("R1");

        // R9: an offload to register 0 marks nothing; reading x0 issues and returns 0
        drv(1, 0, 0, 0, 0, 0, 1, 1, 1, 0, 0, 0);
        cycle("R9");
        drv(1, 0, 1, 0, 1, 0, 1, 0, 0, 0, 0, 0);
        cycle("R9");

        // R6: offload refused by the accelerator; nothing pending afterwards
        drv(1, 0, 0, 0, 0, 6, 1, 1, 0, 0, 0, 0);
        cycle("R6");
        drv(1, 6, 1, 0, 0, 11, 1, 0, 0, 0, 0, 0);
        cycle("R6");

        // R10 / R7: stalled reader while the writeback lands, issues the next cycle
        drv(1, 0, 0, 0, 0, 7, 1, 1, 1, 0, 0, 0);
        cycle("R5");
        drv(1, 7, 1, 0, 0, 12, 1, 0, 0, 1, 7, 32'hCAFE_0007);
        cycle("R10");
        drv(1, 7, 1, 0, 0, 12, 1, 0, 0, 0, 0, 0);
        #1 chk("R10", "rs1_data after writeback", d1, 32'hCAFE_0007);
        cycle("R10");

        // R4 then R5: overwrite of a pending register stalls; an independent one issues
        drv(1, 0, 0, 0, 0, 8, 1, 1, 1, 0, 0, 0);
        cycle("R5");
        drv(1, 0, 0, 0, 0, 8, 1, 0, 0, 0, 0, 0);
        cycle("R4");
        drv(1, 9, 1, 13, 1, 14, 1, 0, 0, 0, 0, 0);
        cycle("R5");
        drv(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 8, 32'h0000_0888);
        cycle("R7");

        // R8: writeback and new offload to the same register in one cycle -> pending
        drv(1, 0, 0, 0, 0, 10, 1, 1, 1, 1, 10, 32'h1234_5678);
        cycle("R8");
        drv(1, 10, 1, 0, 0, 15, 1, 0, 0, 0, 0, 0);
        #1 chk("R8", "stall on register left pending", 32'(stall), 32'd1);
        cycle("R8");
        drv(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 10, 32'h0000_0AAA);
        cycle("R7");
        idle();

        // Random phase: small register range for frequent collisions
        for (int n = 0; n < 3000; n++) begin
            logic [4:0] pick;
            logic found;
            found = 1'b0;
            pick  = 5'($urandom_range(0, 7));
            for (int k = 0; k < 8; k++) begin
                if (!found && m_pend[(pick + 5'(k)) & 5'd7]) begin
                    found = 1'b1;
                    pick  = (pick + 5'(k)) & 5'd7;
                end
            end
            drv(($urandom_range(0, 99) < 85), 5'($urandom_range(0, 7)), 1'($urandom),
                5'($urandom_range(0, 7)), 1'($urandom), 5'($urandom_range(0, 7)), 1'($urandom),
                ($urandom_range(0, 99) < 40), ($urandom_range(0, 99) < 70),
                found && 1'($urandom), pick, $urandom);
            cycle("");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule